// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bus Controller

This block sits behind the pins of a byte-wide asynchronous static memory and turns the pin activity into clean, clock-synchronous accesses to an internal memory array. It watches three active-low strobes: chip select, output enable and write strobe. It also samples a 19-bit address and an 8-bit input data bus, plus a power-fail flag. Every pin goes through a two-flop synchronizer, so decoding happens on the system clock and the analog timing limits become counts of clock cycles.

A read is in progress while chip select is low and the write strobe is high. The output drivers are turned on only while output enable is also low. A write window opens when the later of chip select or write strobe falls, and it closes when the earlier of the two rises. Address and data seen on the last clock of the window are committed to the array one clock after the close is detected. After each committed write the bus must stay quiet for a programmable recovery time. A write that opens too early is dropped, and an error flag is raised. While the power-fail flag is set, no read or write gets through.

The data bus is split into an input, an output and a separate output-enable, so the pad ring can build the tri-state buffer.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, `dq_oe` is 0, `dq_out` is 0x00 and `rec_err` is 0.
- R2: With `ce_n`=0, `we_n`=1 and `oe_n`=0 held steady, `dq_oe` becomes 1 and `dq_out` shows the byte stored at the addressed location within 4 clock cycles.
- R3: While either `ce_n` or `oe_n` is high, `dq_oe` is 0 and `dq_out` is 0x00.
- R4: If `we_n` falls while the outputs are enabled, `dq_oe` drops to 0 within 4 cycles.
- R5: A write window opens when the later of `ce_n`/`we_n` falls and closes when the earlier one rises. Every ordering of these edges produces exactly one write.
- R6: The byte committed is the address and data present on the last sampled cycle of the window. Data changed partway through the window is replaced by its final value.
- R7: While `pwr_fail` is 1, reads leave `dq_oe` at 0 and writes leave the array unchanged. A window during which `pwr_fail` rises commits nothing.
- R8: A write window opened within `TREC` cycles after a committed write is ignored. `rec_err` is 1 from its detection until `ce_n` or `we_n` returns high.
- R9: A write opened after the recovery time has passed is committed normally.
- R10: Storage decodes the low `MEM_AW` bits of the 19-bit address, so locations that differ only above bit `MEM_AW-1` map to the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data from the bus |
| dq_out | output | DATA_W | Data to the bus (0 when not driving) |
| dq_oe | output | 1 | Pad driver enable for `dq_out` |
| pwr_fail | input | 1 | Power-fail flag, active high, blocks access |
| rec_err | output | 1 | Write attempted inside the recovery time |

## Verification
The hardest state to reach is a write strobe that reopens while the recovery counter is still running. The counter starts only after the close has passed through the synchronizer and the commit stage. The bench therefore closes a write and reasserts both strobes two cycles later, which lands inside an 8-cycle recovery time. It then reads the location to show that the late data was dropped. Power failure that arrives in the middle of an open window is reached the same way: the window is held open, `pwr_fail` is raised, and the window is released only after that.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  // synchronized, active-high control levels
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
    logic pf;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sram_sync.sv
module sram_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm #(
  parameter int AW   = 10,
  parameter int DW   = 8,
  parameter int TREC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  sram_ctrl_pkg::ctrl_t lvl,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          win,
  output logic          ign,
  output logic          rec_busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CW = (TREC < 1) ? 1 : $clog2(TREC + 1);
  localparam logic [CW-1:0] TREC_V = CW'(TREC);

  logic          cw, cw_q, cw_rise, commit;
  logic [CW-1:0] rec_cnt;
  logic [AW-1:0] hold_a;
  logic [DW-1:0] hold_d;

  assign cw       = lvl.ce & lvl.we;
  assign cw_rise  = cw & ~cw_q;
  assign rec_busy = (rec_cnt != '0);
  assign commit   = win & ~cw & ~lvl.pf;

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q   <= 1'b0;
      win    <= 1'b0;
      ign    <= 1'b0;
      hold_a <= '0;
      hold_d <= '0;
    end else begin
      cw_q <= cw;
      if (lvl.pf) begin
        win <= 1'b0;               // cancel any open window
        ign <= 1'b0;
      end else if (win) begin
        if (!cw) win <= 1'b0;      // earlier rising edge closes
        else begin
          hold_a <= addr_s;
          hold_d <= data_s;
        end
      end else if (ign) begin
        if (!cw) ign <= 1'b0;
      end else if (cw_rise) begin  // later falling edge opens
        if (rec_busy) ign <= 1'b1;
        else begin
          win    <= 1'b1;
          hold_a <= addr_s;
          hold_d <= data_s;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_cnt <= '0;
    else if (commit) rec_cnt <= TREC_V;
    else if (rec_busy) rec_cnt <= rec_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= commit;
      wr_addr <= hold_a;
      wr_data <= hold_d;
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10,
  parameter int TREC   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              pwr_fail,
  output logic              rec_err
);
  import sram_ctrl_pkg::*;
  localparam int SA = (MEM_AW < ADDR_W) ? MEM_AW : ADDR_W;
  localparam int BW = SA + DATA_W;

  ctrl_t        lvl_raw, lvl;
  logic [SA-1:0]     addr_s, wr_addr;
  logic [DATA_W-1:0] data_s, wr_data, rd_data;
  logic [BW-1:0]     bus_s;
  logic              win, ign, rec_busy, wr_en;
  logic              rd_ok, rd_ok_q;
  logic [ADDR_W-1:0] addr_unused;

  assign lvl_raw = '{ce: ~ce_n, oe: ~oe_n, we: ~we_n, pf: pwr_fail};
  assign addr_unused = addr;

  sram_sync #(.W(CTRL_W)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(lvl_raw), .q(lvl));
  sram_sync #(.W(BW)) u_sync_bus (
    .clk(clk), .rst(rst), .d({addr_unused[SA-1:0], dq_in}), .q(bus_s));

  assign addr_s = bus_s[BW-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  sram_cycle_fsm #(.AW(SA), .DW(DATA_W), .TREC(TREC)) u_fsm (
    .clk(clk), .rst(rst), .lvl(lvl), .addr_s(addr_s), .data_s(data_s),
    .win(win), .ign(ign), .rec_busy(rec_busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data));

  sram_array #(.AW(SA), .DW(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_s), .rd_data(rd_data));

  // read gating: write strobe or power fail forces drivers off
  assign rd_ok = lvl.ce & lvl.oe & ~lvl.we & ~lvl.pf;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q <= 1'b0;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
    end else begin
      rd_ok_q <= rd_ok;
      dq_oe   <= rd_ok_q;
      dq_out  <= rd_ok_q ? rd_data : '0;
    end
  end

  assign rec_err = ign;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker (
  input logic clk,
  input logic rst,
  input logic win,
  input logic ign,
  input logic rec_busy,
  input logic wr_en,
  input logic pf_s,
  input logic dq_oe,
  input logic rec_err
);
  // R7: an array write never follows a cycle with power fail
  assert_no_write_in_pf_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(pf_s));
  // R7: drivers never on when power fail was seen two cycles back
  assert_no_drive_in_pf_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !$past(pf_s, 2));
  // R5: a commit happens only as the window closes
  assert_commit_on_close_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(win) && !win));
  // R8: a window never opens during recovery
  assert_open_after_rec_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(win) |-> !$past(rec_busy));
  // R8: an ignored attempt and an open window never coexist
  assert_win_ign_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({win, ign}));
  // R8: error flag set only from idle during recovery
  assert_err_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rec_err) |-> ($past(rec_busy) && !$past(win)));
endmodule

bind sram_bus_ctrl sram_ctrl_checker u_chk (
  .clk(clk), .rst(rst), .win(win), .ign(ign), .rec_busy(rec_busy),
  .wr_en(wr_en), .pf_s(lvl.pf), .dq_oe(dq_oe), .rec_err(rec_err));

// File: tb/tb_sram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bus_ctrl;
  localparam int AW = 19, DW = 8, MAW = 4, TREC = 8;
  localparam int N = 1 << MAW;

  logic clk = 0, rst = 1;
  logic ce_n = 1, oe_n = 1, we_n = 1, pwr_fail = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, rec_err;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW), .TREC(TREC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .pwr_fail(pwr_fail), .rec_err(rec_err));

  function automatic logic [7:0] pat(int a, int k);
    return 8'((a * 37 + k * 11 + 5) & 8'hFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(int a, logic [7:0] d);
    addr = AW'(a); dq_in = d;
    ce_n = 0; idle(2);
    we_n = 0; idle(4);
    we_n = 1; idle(1);
    ce_n = 1; idle(TREC + 6);
  endtask

  task automatic do_read(int a, output logic [7:0] d, output logic oe);
    addr = AW'(a); we_n = 1;
    ce_n = 0; oe_n = 0; idle(6);
    d = dq_out; oe = dq_oe;
    ce_n = 1; oe_n = 1; idle(6);
  endtask

  task automatic expect_byte(int a, logic [7:0] e, string req);
    logic [7:0] d; logic oe;
    do_read(a, d, oe);
    chk(oe === 1'b1 && d === e, req, int'(d), int'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic oe;
    idle(3); rst = 0; idle(1);
    // R1
    chk(dq_oe === 0, "R1 dq_oe", int'(dq_oe), 0);
    chk(dq_out === 0, "R1 dq_out", int'(dq_out), 0);
    chk(rec_err === 0, "R1 rec_err", int'(rec_err), 0);

    // R9 / R2: sweep all locations, write then read back
    for (int a = 0; a < N; a++) do_write(a, pat(a, 0));
    for (int a = 0; a < N; a++) expect_byte(a, pat(a, 0), "R2 R9 readback");

    // R10: aliasing above MEM_AW
    for (int a = 0; a < N; a++) begin
      expect_byte(a | (1 << MAW), pat(a, 0), "R10 alias low");
      expect_byte(a | (1 << 18), pat(a, 0), "R10 alias top");
    end

    // R3: oe_n high or ce_n high keeps drivers off
    addr = AW'(3); ce_n = 0; oe_n = 1; idle(6);
    chk(dq_oe === 0 && dq_out === 0, "R3 oe_n high", int'(dq_oe), 0);
    ce_n = 1; oe_n = 0; idle(6);
    chk(dq_oe === 0 && dq_out === 0, "R3 ce_n high", int'(dq_oe), 0);
    oe_n = 1; idle(4);

    // R4: write strobe falling during read turns drivers off
    addr = AW'(5); dq_in = pat(5, 0); ce_n = 0; oe_n = 0; idle(6);
    chk(dq_oe === 1, "R4 driving before", int'(dq_oe), 1);
    we_n = 0; idle(4);
    chk(dq_oe === 0, "R4 off after we_n", int'(dq_oe), 0);
    we_n = 1; ce_n = 1; oe_n = 1; idle(TREC + 6);

    // R5: we_n falls first, ce_n falls second; ce_n rises first
    addr = AW'(6); dq_in = 8'hA6;
    we_n = 0; idle(3); ce_n = 0; idle(4); ce_n = 1; idle(2); we_n = 1;
    idle(TREC + 6);
    expect_byte(6, 8'hA6, "R5 we-first ce-close");
    // R5: ce_n first, we_n second; we_n rises first
    addr = AW'(7); dq_in = 8'hB7;
    ce_n = 0; idle(3); we_n = 0; idle(4); we_n = 1; idle(2); ce_n = 1;
    idle(TREC + 6);
    expect_byte(7, 8'hB7, "R5 ce-first we-close");
    expect_byte(8, pat(8, 0), "R5 neighbour untouched");

    // R6: data changes mid-window, final value wins
    addr = AW'(9); dq_in = 8'h11;
    ce_n = 0; we_n = 0; idle(3); dq_in = 8'h99; idle(4);
    we_n = 1; ce_n = 1; idle(TREC + 6);
    expect_byte(9, 8'h99, "R6 last data");

    // R7: read under power fail
    pwr_fail = 1; idle(3);
    addr = AW'(2); ce_n = 0; oe_n = 0; idle(6);
    chk(dq_oe === 0 && dq_out === 0, "R7 read blocked", int'(dq_oe), 0);
    ce_n = 1; oe_n = 1; idle(2);
    // R7: write under power fail
    do_write(2, 8'h5A);
    pwr_fail = 0; idle(4);
    expect_byte(2, pat(2, 0), "R7 write blocked");
    // R7: power fail rises mid-window
    addr = AW'(4); dq_in = 8'hC4;
    ce_n = 0; we_n = 0; idle(5); pwr_fail = 1; idle(4);
    we_n = 1; ce_n = 1; idle(4); pwr_fail = 0; idle(TREC + 6);
    expect_byte(4, pat(4, 0), "R7 window cancelled");

    // R8: reopen inside recovery
    addr = AW'(10); dq_in = 8'hE1;
    ce_n = 0; we_n = 0; idle(4); we_n = 1; idle(1); ce_n = 1;
    idle(2);
    dq_in = 8'h3C; ce_n = 0; we_n = 0; idle(5);
    chk(rec_err === 1, "R8 rec_err set", int'(rec_err), 1);
    we_n = 1; ce_n = 1; idle(5);
    chk(rec_err === 0, "R8 rec_err clears", int'(rec_err), 0);
    idle(TREC + 6);
    expect_byte(10, 8'hE1, "R8 late write dropped");
    // R9: after recovery a new write lands
    do_write(10, 8'h3C);
    chk(rec_err === 0, "R9 no error", int'(rec_err), 0);
    expect_byte(10, 8'h3C, "R9 accepted");

    // second sweep with different pattern, mixed orderings (R5 R9)
    for (int a = 0; a < N; a++) begin
      addr = AW'(a); dq_in = pat(a, 1);
      if (a % 2 == 0) begin
        ce_n = 0; idle(2); we_n = 0; idle(4); ce_n = 1; idle(1); we_n = 1;
      end else begin
        we_n = 0; idle(2); ce_n = 0; idle(4); we_n = 1; idle(1); ce_n = 1;
      end
      idle(TREC + 6);
    end
    for (int a = 0; a < N; a++) expect_byte(a, pat(a, 1), "R5 sweep2");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule